// File: doc/BRIEF.md
# Front Panel LED Serial Shifter

This block drives the front-panel LEDs of an appliance through an external 8-bit serial-in, parallel-out shift register that has only a data input and a clock input. It takes four disk fault flags and a system LED state, turns them into a fixed 8-bit pattern, and clocks that pattern out one bit at a time. The register has no output latch, so its outputs ripple while a transfer is in progress. The green disk activity LEDs are driven elsewhere and are not handled here.

An update is offered on a valid/ready handshake. The pattern inputs are sampled in the cycle where `upd_valid` and `upd_ready` are both high. While a transfer is running, `upd_ready` is low and `busy` is high, and any `upd_valid` is left pending and has no effect. A producer that needs its update applied holds `upd_valid` high until it sees `upd_ready`. Each bit goes out as follows: the data line is set first, it is held for a setup time (`SETUP_CYC` clock cycles, about 1 us by default), and then the clock line is pulsed high for `HIGH_CYC` cycles.

Top module: `led_panel_shifter`

## Requirements
- R1: Pattern bits 0 and 7 are always 1.
- R2: `sys_state` uses the encoding 2'b00 off, 2'b01 blue, 2'b10 red and 2'b11 off. Blue sets pattern bit 2 and red sets pattern bit 3. Off leaves both bits clear.
- R3: `disk_red[0]`, `disk_red[1]`, `disk_red[2]` and `disk_red[3]` (disks 1 to 4) control pattern bits 1, 6, 5 and 4 in that order. Each of these bits is active-low: it is 0 when its disk flag is 1 and 1 when the flag is 0.
- R4: Each accepted update produces exactly 8 rising edges on `led_sclk`, sending the pattern LSB first. Afterwards an external register that shifts `led_sdata` into its stage Q0 on each rising edge holds Q[i] = pattern[7-i].
- R5: Before each rising edge of `led_sclk`, `led_sdata` has been stable and `led_sclk` has been low for exactly `SETUP_CYC` cycles. `led_sclk` then stays high for exactly `HIGH_CYC` cycles, and `led_sdata` does not change while it is high.
- R6: While reset is asserted and after it is released, `led_sdata` and `led_sclk` are low, `busy` is low and `upd_ready` is high.
- R7: An update is accepted in the cycle where `upd_valid` and `upd_ready` are both high. The pattern inputs are sampled in that cycle, and changes to them afterwards do not affect the transfer.
- R8: While `busy` is high, `upd_ready` is low and `upd_valid` is ignored. No additional transfer follows the current one.
- R9: After the eighth clock pulse, `led_sdata` and `led_sclk` both return low, and `busy` falls in the same cycle that the last pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disk_red | input | 4 | Red fault flag per disk, bit 0 is disk 1 |
| sys_state | input | 2 | System LED: 00 off, 01 blue, 10 red, 11 off |
| upd_valid | input | 1 | Update request |
| upd_ready | output | 1 | Update accepted when high together with valid |
| busy | output | 1 | Transfer in progress |
| led_sdata | output | 1 | Serial data to external shift register |
| led_sclk | output | 1 | Shift clock to external shift register |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge, and that the pattern inputs only matter in the cycle an update is accepted. They place no requirement on `upd_valid` while `busy` is high. The stimulus drives inputs on the falling edge only. It draws random disk flags and system codes, including the code 2'b11, and covers directed cases for all-red, all-clear and each colour. It drops `upd_valid` and scrambles the pattern inputs right after acceptance. It also raises `upd_valid` in the middle of transfers and releases it before the transfer ends, so that an ignored request can be seen in the register model at the ports.

// File: rtl/led_shift_pkg.sv
package led_shift_pkg;
  localparam int PAT_W    = 8;
  localparam int NUM_DISK = 4;

  typedef enum logic [1:0] {
    SYS_OFF  = 2'b00,
    SYS_BLUE = 2'b01,
    SYS_RED  = 2'b10,
    SYS_OFF2 = 2'b11
  } sys_led_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_SETUP = 2'b01,
    PH_PULSE = 2'b10
  } phase_t;

  // Fixed positions decoded by the board wiring
  localparam int POS_FIXED_LO = 0;
  localparam int POS_FIXED_HI = 7;
  localparam int POS_BLUE     = 2;
  localparam int POS_RED      = 3;
  localparam int POS_DISK [NUM_DISK] = '{1, 6, 5, 4};
endpackage

// File: rtl/led_pattern_map.sv
module led_pattern_map
  import led_shift_pkg::*;
(
  input  logic [NUM_DISK-1:0] disk_red,
  input  logic [1:0]          sys_state,
  output logic [PAT_W-1:0]    pattern
);
  logic [PAT_W-1:0] disk_bits;
  logic [PAT_W-1:0] sys_bits;

  for (genvar d = 0; d < NUM_DISK; d++) begin : g_disk
    assign disk_bits[POS_DISK[d]] = ~disk_red[d];
  end
  assign disk_bits[POS_FIXED_LO] = 1'b1;
  assign disk_bits[POS_FIXED_HI] = 1'b1;
  assign disk_bits[POS_BLUE]     = 1'b0;
  assign disk_bits[POS_RED]      = 1'b0;

  always_comb begin
    sys_bits = '0;
    unique case (sys_led_t'(sys_state))
      SYS_BLUE: sys_bits[POS_BLUE] = 1'b1;
      SYS_RED:  sys_bits[POS_RED]  = 1'b1;
      default:  sys_bits = '0;
    endcase
  end

  assign pattern = disk_bits | sys_bits;
endmodule

// File: rtl/led_phase_timer.sv
module led_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [TW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) count <= '0;
    else                 count <= count + 1'b1;
  end
endmodule

// File: rtl/led_serializer.sv
module led_serializer
  import led_shift_pkg::*;
#(
  parameter int SETUP_CYC = 125,
  parameter int HIGH_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PAT_W-1:0] pattern,
  output logic             busy,
  output logic             sdata,
  output logic             sclk
);
  localparam int MAXC = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int BW   = $clog2(PAT_W);
  localparam logic [TW-1:0] SETUP_LAST = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] HIGH_LAST  = TW'(HIGH_CYC - 1);
  localparam logic [BW-1:0] BIT_LAST   = BW'(PAT_W - 1);

  phase_t           phase;
  logic [PAT_W-1:0] shreg;
  logic [BW-1:0]    bit_idx;
  logic [TW-1:0]    tcount;
  logic             accept;
  logic             setup_done;
  logic             pulse_done;

  assign accept     = start && (phase == PH_IDLE);
  assign setup_done = (phase == PH_SETUP) && (tcount == SETUP_LAST);
  assign pulse_done = (phase == PH_PULSE) && (tcount == HIGH_LAST);
  assign busy       = (phase != PH_IDLE);

  led_phase_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept || setup_done || pulse_done),
    .count (tcount)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      sdata   <= 1'b0;
      sclk    <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            shreg   <= pattern;
            sdata   <= pattern[0];
            bit_idx <= '0;
            phase   <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (setup_done) begin
            sclk  <= 1'b1;
            phase <= PH_PULSE;
          end
        end
        PH_PULSE: begin
          if (pulse_done) begin
            sclk <= 1'b0;
            if (bit_idx == BIT_LAST) begin
              sdata <= 1'b0;
              phase <= PH_IDLE;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              shreg   <= shreg >> 1;
              sdata   <= shreg[1];
              phase   <= PH_SETUP;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Independent count of clock rises for the pulse-count check
  logic       sclk_d;
  logic [4:0] rise_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk;
      if (accept)             rise_cnt <= '0;
      else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_eight_pulses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (rise_cnt == 5'(PAT_W)));

  assert_data_steady_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));

  assert_data_before_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdata));

  assert_idle_lines_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !sdata));
endmodule

// File: rtl/led_panel_shifter.sv
module led_panel_shifter
  import led_shift_pkg::*;
#(
  parameter int SETUP_CYC = 125,
  parameter int HIGH_CYC  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_DISK-1:0] disk_red,
  input  logic [1:0]          sys_state,
  input  logic                upd_valid,
  output logic                upd_ready,
  output logic                busy,
  output logic                led_sdata,
  output logic                led_sclk
);
  logic [PAT_W-1:0] pattern;
  logic             ser_busy;

  led_pattern_map u_map (
    .disk_red  (disk_red),
    .sys_state (sys_state),
    .pattern   (pattern)
  );

  led_serializer #(.SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (upd_valid),
    .pattern (pattern),
    .busy    (ser_busy),
    .sdata   (led_sdata),
    .sclk    (led_sclk)
  );

  assign busy      = ser_busy;
  assign upd_ready = !ser_busy;

  assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=> (busy && !led_sclk && (led_sdata == $past(pattern[0]))));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(upd_ready)) |-> !upd_ready);
endmodule

// File: tb/led_panel_shifter_test.sv
`timescale 1ns/1ps
module led_panel_shifter_test;
  localparam int SETUP_CYC = 125;
  localparam int HIGH_CYC  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] disk_red = '0;
  logic [1:0] sys_state = '0;
  logic       upd_valid = 1'b0;
  logic       upd_ready, busy, led_sdata, led_sclk;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  led_panel_shifter #(.SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .disk_red(disk_red), .sys_state(sys_state),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .busy(busy),
    .led_sdata(led_sdata), .led_sclk(led_sclk)
  );

  // External SIPO register model: Q0 takes data, others shift up
  logic [7:0] ext_q = '0;
  always @(posedge led_sclk) ext_q <= {ext_q[6:0], led_sdata};

  function automatic logic [7:0] expect_pat(input logic [3:0] dr, input logic [1:0] ss);
    logic [7:0] p;
    p = 8'h81;
    if (ss == 2'b01) p[2] = 1'b1;
    if (ss == 2'b10) p[3] = 1'b1;
    p[1] = ~dr[0];
    p[6] = ~dr[1];
    p[5] = ~dr[2];
    p[4] = ~dr[3];
    return p;
  endfunction

  function automatic logic [7:0] expect_q(input logic [7:0] p);
    logic [7:0] q;
    for (int i = 0; i < 8; i++) q[i] = p[7-i];
    return q;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Line timing monitor, sampled on falling edges
  int  rises = 0;
  int  low_run = 0;
  int  high_run = 0;
  logic prev_sclk = 1'b0;
  logic prev_sdata = 1'b0;
  always @(negedge clk) begin
    if (rst_n && busy) begin
      if (led_sclk && !prev_sclk) begin
        rises++;
        check("R5 setup", low_run, SETUP_CYC);
        check("R5 data at rise", led_sdata, prev_sdata);
        high_run = 1;
      end else if (led_sclk) begin
        high_run++;
        check("R5 data while high", led_sdata, prev_sdata);
      end
      if (!led_sclk) begin
        if (prev_sclk) low_run = 0;
        low_run++;
      end
    end else begin
      if (!led_sclk && prev_sclk) check("R5 high width", high_run, HIGH_CYC);
      low_run = 0;
    end
    if (rst_n && busy && !led_sclk && prev_sclk) check("R5 high width", high_run, HIGH_CYC);
    prev_sclk  = led_sclk;
    prev_sdata = led_sdata;
  end

  task automatic send(input logic [3:0] dr, input logic [1:0] ss, input bit poke);
    int r0;
    logic [7:0] p;
    @(negedge clk);
    while (!upd_ready) @(negedge clk);
    r0 = rises;
    p = expect_pat(dr, ss);
    disk_red = dr;
    sys_state = ss;
    upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    disk_red = 4'($urandom);
    sys_state = 2'($urandom);
    check("R7 busy after accept", {busy, upd_ready}, 2'b10);
    if (poke) begin
      repeat (300) @(negedge clk);
      upd_valid = 1'b1;
      repeat (5) @(negedge clk);
      check("R8 ready low while busy", upd_ready, 1'b0);
      upd_valid = 1'b0;
    end
    while (!upd_ready) @(negedge clk);
    check("R9 lines low at end", {led_sdata, led_sclk}, 2'b00);
    check("R4 pulse count", rises - r0, 8);
    check("R1 R2 R3 R4 register contents", ext_q, expect_q(p));
    if (poke) begin
      repeat (20) @(negedge clk);
      check("R8 no extra transfer", {busy, rises - r0}, {1'b0, 32'd8});
      check("R8 register unchanged", ext_q, expect_q(p));
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R6 reset lines", {led_sdata, led_sclk}, 2'b00);
    check("R6 reset handshake", {busy, upd_ready}, 2'b01);
    upd_valid = 1'b1;
    @(negedge clk);
    check("R6 valid ignored in reset", busy, 1'b0);
    upd_valid = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 after release", {busy, upd_ready, led_sdata, led_sclk}, 4'b0100);

    send(4'b0000, 2'b01, 1'b0);  // R2 blue, R3 all clear
    send(4'b1111, 2'b10, 1'b0);  // R2 red, R3 all red
    send(4'b0000, 2'b00, 1'b0);  // R1 only fixed bits + disks
    send(4'b1111, 2'b11, 1'b0);  // R2 code 11 is off
    send(4'b0001, 2'b00, 1'b0);  // R3 disk 1
    send(4'b0010, 2'b00, 1'b0);  // R3 disk 2
    send(4'b0100, 2'b00, 1'b0);  // R3 disk 3
    send(4'b1000, 2'b01, 1'b1);  // R3 disk 4, R8 poke
    for (int n = 0; n < 30; n++)
      send(4'($urandom), 2'($urandom), ($urandom % 4) == 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule